// File: doc/BRIEF.md
# Bipolar Line Code Decoder

This block turns the two rails of a recovered bipolar line signal, one for positive pulses and one for negative pulses, into a single NRZ data bit per clock. It also raises an error flag for line code faults. A code select picks plain alternate mark inversion, the eight-zero substitution code used on T1 links, or the four-zero substitution code used on E1 links. In both substitution codes the inserted pulse groups are recognised and turned back into zeros. Each code has its own rule for what counts as an error. Zero-run errors are reported only for the E1 code.

A decode enable picks between two uses. With decoding on, the block gives NRZ data and an error flag. With decoding off, the two rails come out unchanged on the same pins. Every symbol goes through a fixed eight-slot window, so substitution groups can be cleared before their bits leave. The latency is the same in every code. An edge select decides whether the outputs change on the rising or the falling clock edge.

The polarity of the last mark is kept by a small state machine. Its states are MK_NONE (no mark since reset), MK_POS (last mark positive) and MK_NEG (last mark negative). Any mark moves it to MK_POS or MK_NEG according to the mark's polarity. A mark on both rails at once counts as the polarity opposite to the previous mark, or as positive from MK_NONE. A cycle with no mark leaves the state unchanged. Synchronous reset returns it to MK_NONE.

Top module: `bipolar_line_decoder`

## Requirements
- R1: With decode enable low, the data output repeats the positive rail and the flag output repeats the negative rail, with the same latency as decoding and no error reporting.
- R2: In AMI mode (code select 0 or 3), every mark decodes to 1 and every zero to 0. Every mark with the same polarity as the mark before it is flagged, and no pulse group is removed.
- R3: In E1 mode (code select 2), a violation after exactly three zeros (000V), or after a mark and two zeros (B00V), is output as four zeros with no flag.
- R4: In E1 mode, a violation that fits neither pattern is output as a 1 and flagged.
- R5: In E1 mode, the fourth consecutive zero on the line is flagged. The flag is raised once per run, however long the run is.
- R6: In T1 mode (code select 1), the group zero, zero, zero, V, B, zero, V, B is output as eight zeros with no flag. Here each V repeats the polarity of the mark before it and each B alternates.
- R7: In T1 mode, a violation outside that group is flagged, and zero runs of any length are never flagged.
- R8: With decoding on, a pulse on both rails in one cycle is output as a 1 and flagged.
- R9: With the edge select low, a symbol sampled at rising edge k appears on the outputs just after rising edge k+8. With the edge select high, it appears at the falling edge between rising edges k+7 and k+8.
- R10: While reset is active, and after reset until the first new symbol comes through, both outputs are 0. Reset also clears the last-mark memory, so the first mark after reset is never flagged.
- R11: Each error flag lasts exactly one clock cycle, in the output slot of the symbol that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered line clock |
| rst | input | 1 | Synchronous reset, active high |
| line_pos_i | input | 1 | Positive rail pulse |
| line_neg_i | input | 1 | Negative rail pulse |
| decode_en_i | input | 1 | 1: single-rail decode, 0: rails pass through |
| code_sel_i | input | 2 | 0 AMI, 1 T1 eight-zero substitution, 2 E1 four-zero substitution, 3 AMI |
| fall_edge_i | input | 1 | 1: outputs change on falling edge, 0: on rising edge |
| nrz_o | output | 1 | Decoded data, or positive rail when not decoding |
| flag_o | output | 1 | Line code error pulse, or negative rail when not decoding |

## Verification
Short directed line patterns compare clean substitution groups with near-misses. A group that stops one pulse short, a lone violation right after a mark, and zero runs of four to six show whether the pattern matching is exact or only approximate. The same E1-looking pulses fed in AMI mode show that each code uses its own rules. Long random streams from independent AMI, T1 and E1 encoders cover mixed zero-run lengths and both substitution choices, and one polarity inversion in each stream produces exactly one flag. Both-rail pulses, passthrough, reset in the middle of a stream and the two output edges are tested on their own.

// File: rtl/bld_pkg.sv
package bld_pkg;

    typedef enum logic [1:0] {
        CODE_AMI  = 2'd0,
        CODE_B8ZS = 2'd1,
        CODE_HDB3 = 2'd2,
        CODE_RSVD = 2'd3
    } line_code_e;

    typedef enum logic [1:0] {
        MK_NONE = 2'd0,
        MK_POS  = 2'd1,
        MK_NEG  = 2'd2
    } last_mark_e;

    // one symbol slot travelling through the decode window
    typedef struct packed {
        logic rp;   // raw positive rail
        logic rn;   // raw negative rail
        logic d;    // decoded data bit
        logic v;    // unresolved polarity violation
        logic x;    // hard error (both rails, zero run)
    } slot_t;

    // longest substitution group (T1) spans eight symbols
    localparam int unsigned WIN_LEN = 8;

endpackage

// File: rtl/bld_mark_tracker.sv
module bld_mark_tracker
    import bld_pkg::*;
#(
    parameter int unsigned ZERO_LIMIT = 4,
    parameter int unsigned ZW         = $clog2(ZERO_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pos_i,
    input  logic          neg_i,
    output logic          mark_o,
    output logic          both_o,
    output logic          bpv_o,
    output logic [ZW-1:0] zrun_o
);

    last_mark_e    state_q, state_d;
    logic [ZW-1:0] zcnt_q;
    logic          pol_pos;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MK_NONE;
        end else begin
            state_q <= state_d;
        end
    end

    // classification and next state
    always_comb begin
        mark_o = pos_i | neg_i;
        both_o = pos_i & neg_i;
        unique case (state_q)
            MK_NONE: begin
                pol_pos = both_o ? 1'b1 : pos_i;
                bpv_o   = 1'b0;
            end
            MK_POS: begin
                pol_pos = both_o ? 1'b0 : pos_i;
                bpv_o   = mark_o && !both_o && pos_i;
            end
            MK_NEG: begin
                pol_pos = both_o ? 1'b1 : pos_i;
                bpv_o   = mark_o && !both_o && !pos_i;
            end
            default: begin
                pol_pos = pos_i;
                bpv_o   = 1'b0;
            end
        endcase
        state_d = state_q;
        if (mark_o) begin
            state_d = pol_pos ? MK_POS : MK_NEG;
        end
    end

    // zeros seen since the last mark, saturating
    always_ff @(posedge clk) begin
        if (rst) begin
            zcnt_q <= '0;
        end else if (mark_o) begin
            zcnt_q <= '0;
        end else if (zcnt_q != ZW'(ZERO_LIMIT)) begin
            zcnt_q <= zcnt_q + 1'b1;
        end
    end

    assign zrun_o = zcnt_q;

endmodule

// File: rtl/bld_window.sv
module bld_window
    import bld_pkg::*;
#(
    parameter int unsigned ZERO_LIMIT = 4,
    parameter int unsigned ZW         = $clog2(ZERO_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  line_code_e    code_i,
    input  logic          pos_i,
    input  logic          neg_i,
    input  logic          mark_i,
    input  logic          both_i,
    input  logic          bpv_i,
    input  logic [ZW-1:0] zrun_i,
    output slot_t         tail_o
);

    slot_t              dl_q [WIN_LEN];
    slot_t              nx   [WIN_LEN];
    logic [WIN_LEN-1:0] occ;
    logic               hdb_sel, b8_sel;
    logic               hdb_sub, hdb_b00v, excess, b8_match;

    // raw line occupancy of each slot
    for (genvar g = 0; g < WIN_LEN; g++) begin : g_occ
        assign occ[g] = dl_q[g].rp | dl_q[g].rn;
    end

    always_comb begin
        hdb_sel = 1'b0;
        b8_sel  = 1'b0;
        unique case (code_i)
            CODE_HDB3: hdb_sel = en_i;
            CODE_B8ZS: b8_sel  = en_i;
            default:   ;
        endcase

        hdb_sub  = hdb_sel && bpv_i && (zrun_i == ZW'(3) || zrun_i == ZW'(2));
        hdb_b00v = hdb_sel && bpv_i && (zrun_i == ZW'(2));
        excess   = hdb_sel && !mark_i && (zrun_i == ZW'(ZERO_LIMIT - 1));
        // incoming symbol is the closing B; slots 0..6 hold the rest
        b8_match = b8_sel && mark_i && !bpv_i && !both_i
                && occ[0] && dl_q[0].v && !occ[1]
                && occ[2] && !dl_q[2].v
                && occ[3] && dl_q[3].v
                && !occ[4] && !occ[5] && !occ[6];

        for (int i = 1; i < WIN_LEN; i++) begin
            nx[i] = dl_q[i-1];
        end
        nx[0].rp = pos_i;
        nx[0].rn = neg_i;
        nx[0].d  = mark_i;
        nx[0].v  = en_i && bpv_i;
        nx[0].x  = en_i && (both_i || excess);

        if (hdb_sub) begin
            nx[0].d = 1'b0;
            nx[0].v = 1'b0;
        end
        if (hdb_b00v) begin
            nx[3].d = 1'b0;   // the B pulse, three symbols back
        end
        if (b8_match) begin
            nx[0].d = 1'b0;
            nx[1].d = 1'b0;
            nx[1].v = 1'b0;
            nx[3].d = 1'b0;
            nx[4].d = 1'b0;
            nx[4].v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WIN_LEN; i++) begin
                dl_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < WIN_LEN; i++) begin
                dl_q[i] <= nx[i];
            end
        end
    end

    assign tail_o = dl_q[WIN_LEN-1];

    // R2: in AMI every violation seen by the tracker lands flagged in the window
    a_r2_ami_flag: assert property (@(posedge clk) disable iff (rst)
        (en_i && code_i == CODE_AMI && bpv_i) |=> dl_q[0].v);

    // R3: a 000V / B00V violation enters the window cleared
    a_r3_hdb3_sub: assert property (@(posedge clk) disable iff (rst)
        (en_i && code_i == CODE_HDB3 && bpv_i && zrun_i == ZW'(3))
        |=> (!dl_q[0].d && !dl_q[0].v));

    // R5: the zero completing an over-long run is marked as an error
    a_r5_zero_run: assert property (@(posedge clk) disable iff (rst)
        (en_i && code_i == CODE_HDB3 && !mark_i && zrun_i == ZW'(ZERO_LIMIT - 1))
        |=> dl_q[0].x);

    // R8: a dual-rail pulse is kept as data and marked as an error
    a_r8_both_rails: assert property (@(posedge clk) disable iff (rst)
        (en_i && both_i) |=> (dl_q[0].x && dl_q[0].d));

endmodule

// File: rtl/bld_edge_out.sv
module bld_edge_out
    import bld_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en_i,
    input  logic  fall_sel_i,
    input  slot_t tail_i,
    output logic  data_o,
    output logic  flag_o
);

    logic data_n, flag_n;
    logic rise_d_q, rise_f_q, fall_d_q, fall_f_q;

    always_comb begin
        data_n = en_i ? tail_i.d : tail_i.rp;
        flag_n = en_i ? (tail_i.v | tail_i.x) : tail_i.rn;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rise_d_q <= 1'b0;
            rise_f_q <= 1'b0;
        end else begin
            rise_d_q <= data_n;
            rise_f_q <= flag_n;
        end
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            fall_d_q <= 1'b0;
            fall_f_q <= 1'b0;
        end else begin
            fall_d_q <= data_n;
            fall_f_q <= flag_n;
        end
    end

    assign data_o = fall_sel_i ? fall_d_q : rise_d_q;
    assign flag_o = fall_sel_i ? fall_f_q : rise_f_q;

endmodule

// File: rtl/bipolar_line_decoder.sv
module bipolar_line_decoder
    import bld_pkg::*;
#(
    parameter int unsigned ZERO_LIMIT = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_pos_i,
    input  logic       line_neg_i,
    input  logic       decode_en_i,
    input  logic [1:0] code_sel_i,
    input  logic       fall_edge_i,
    output logic       nrz_o,
    output logic       flag_o
);

    localparam int unsigned ZW = $clog2(ZERO_LIMIT + 1);

    line_code_e    code;
    logic          mark, both, bpv;
    logic [ZW-1:0] zrun;
    slot_t         tail;

    assign code = line_code_e'(code_sel_i);

    bld_mark_tracker #(.ZERO_LIMIT(ZERO_LIMIT), .ZW(ZW)) u_track (
        .clk    (clk),
        .rst    (rst),
        .pos_i  (line_pos_i),
        .neg_i  (line_neg_i),
        .mark_o (mark),
        .both_o (both),
        .bpv_o  (bpv),
        .zrun_o (zrun)
    );

    bld_window #(.ZERO_LIMIT(ZERO_LIMIT), .ZW(ZW)) u_win (
        .clk    (clk),
        .rst    (rst),
        .en_i   (decode_en_i),
        .code_i (code),
        .pos_i  (line_pos_i),
        .neg_i  (line_neg_i),
        .mark_i (mark),
        .both_i (both),
        .bpv_i  (bpv),
        .zrun_i (zrun),
        .tail_o (tail)
    );

    bld_edge_out u_out (
        .clk        (clk),
        .rst        (rst),
        .en_i       (decode_en_i),
        .fall_sel_i (fall_edge_i),
        .tail_i     (tail),
        .data_o     (nrz_o),
        .flag_o     (flag_o)
    );

endmodule

// File: tb/bipolar_line_decoder_tb.sv
module bipolar_line_decoder_tb;

    localparam int LAT  = 9;
    localparam int MAXN = 260;
    localparam int NV   = 9;

    // {code[66:65], en[64], symbols[63:32] (2 bits each, symbol 0 first: 10=+, 01=-, 11=both),
    //  expected data[31:16], expected flag[15:0] (symbol 0 in MSB)}
    localparam logic [66:0] VECS [NV] = '{
        {2'd0, 1'b1, 32'b10_00_01_10_00_00_01_00_10_01_00_10_00_01_00_00, 16'b1011_0010_1101_0100, 16'b0000_0000_0000_0000},
        {2'd0, 1'b1, 32'b10_00_10_01_01_00_00_00_00_00_00_10_00_00_00_00, 16'b1011_1000_0001_0000, 16'b0010_1000_0000_0000},
        {2'd0, 1'b1, 32'b10_00_11_00_10_00_01_00_00_00_00_00_00_00_00_00, 16'b1010_1010_0000_0000, 16'b0010_0000_0000_0000},
        {2'd2, 1'b1, 32'b10_00_00_00_10_01_00_00_01_10_00_01_00_00_00_01, 16'b1000_0000_0101_0000, 16'b0000_0000_0000_0000},
        {2'd2, 1'b1, 32'b10_00_00_00_00_00_01_10_10_00_00_00_01_00_01_00, 16'b1000_0011_1000_1010, 16'b0000_1000_1000_0010},
        {2'd1, 1'b1, 32'b10_00_00_00_10_01_00_01_10_01_00_10_00_00_01_00, 16'b1000_0000_0101_0010, 16'b0000_0000_0000_0000},
        {2'd1, 1'b1, 32'b10_00_00_00_10_01_00_01_00_10_00_00_00_00_00_00, 16'b1000_1101_0100_0000, 16'b0000_1001_0000_0000},
        {2'd2, 1'b0, 32'b10_00_00_00_10_11_01_00_00_00_00_00_01_01_00_10, 16'b1000_1100_0000_0001, 16'b0000_0110_0000_1100},
        {2'd0, 1'b1, 32'b10_00_00_00_10_01_00_00_01_00_00_00_00_00_00_00, 16'b1000_1100_1000_0000, 16'b0000_1000_1000_0000}
    };

    logic       clk = 1'b0;
    logic       rst, lp, ln, en, fe;
    logic [1:0] code;
    logic       nrz, flag;
    int         total = 0, bad = 0;
    bit         done = 1'b0;

    logic sp [MAXN], sn [MAXN], ed [MAXN], ee [MAXN], dat [MAXN];
    int   nsym;

    always #5 clk = ~clk;

    bipolar_line_decoder u_dut (
        .clk         (clk),
        .rst         (rst),
        .line_pos_i  (lp),
        .line_neg_i  (ln),
        .decode_en_i (en),
        .code_sel_i  (code),
        .fall_edge_i (fe),
        .nrz_o       (nrz),
        .flag_o      (flag)
    );

    function automatic string vec_req(int t);
        case (t)
            0: return "R2";
            1: return "R2 R11";
            2: return "R8";
            3: return "R3";
            4: return "R4 R5";
            5: return "R6";
            6: return "R7";
            7: return "R1";
            default: return "R2";
        endcase
    endfunction

    task automatic check(string req, logic act, logic exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; lp = 1'b0; ln = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic set_sym(int i, int pol);
        sp[i] = (pol > 0);
        sn[i] = (pol < 0);
    endtask

    // drive nsym symbols plus flush, compare each output slot
    task automatic run_stream(string req);
        for (int j = 0; j < nsym + LAT; j++) begin
            @(posedge clk);
            #1;
            if (j < nsym) begin
                lp = sp[j]; ln = sn[j];
            end else begin
                lp = 1'b0; ln = 1'b0;
            end
            #7;
            if (j < LAT) begin
                // R10: cleared pipeline before first symbol arrives
                check("R10", nrz, 1'b0, $sformatf("data before symbols, cycle %0d", j));
                check("R10", flag, 1'b0, $sformatf("flag before symbols, cycle %0d", j));
            end else begin
                check(req, nrz, ed[j-LAT], $sformatf("data sym %0d", j - LAT));
                check(req, flag, ee[j-LAT], $sformatf("flag sym %0d", j - LAT));
            end
        end
    endtask

    task automatic gen_data(int n);
        dat[0] = 1'b1;
        for (int i = 1; i < n; i++) dat[i] = ($urandom_range(0, 9) < 4);
        for (int i = 0; i < n; i++) begin
            ed[i] = dat[i];
            ee[i] = 1'b0;
        end
    endtask

    task automatic enc_ami(int n);
        int lastp = -1;
        for (int i = 0; i < n; i++) begin
            if (dat[i]) begin
                lastp = -lastp;
                set_sym(i, lastp);
            end else begin
                set_sym(i, 0);
            end
        end
    endtask

    task automatic enc_e1(int n);
        int lastp = -1;
        int pulses = 0;
        int i = 0;
        while (i < n) begin
            if (i + 3 < n && !dat[i] && !dat[i+1] && !dat[i+2] && !dat[i+3]) begin
                if (pulses % 2 == 1) begin
                    set_sym(i, 0); set_sym(i+1, 0); set_sym(i+2, 0); set_sym(i+3, lastp);
                end else begin
                    lastp = -lastp;
                    set_sym(i, lastp); set_sym(i+1, 0); set_sym(i+2, 0); set_sym(i+3, lastp);
                end
                pulses = 0;
                i += 4;
            end else begin
                if (dat[i]) begin
                    lastp = -lastp;
                    pulses++;
                    set_sym(i, lastp);
                end else begin
                    set_sym(i, 0);
                end
                i++;
            end
        end
    endtask

    task automatic enc_t1(int n);
        int lastp = -1;
        int i = 0;
        while (i < n) begin
            bit z8 = (i + 7 < n);
            for (int k = 0; k < 8; k++) if (z8 && dat[i+k]) z8 = 1'b0;
            if (z8) begin
                set_sym(i, 0); set_sym(i+1, 0); set_sym(i+2, 0);
                set_sym(i+3, lastp); set_sym(i+4, -lastp); set_sym(i+5, 0);
                set_sym(i+6, -lastp); set_sym(i+7, lastp);
                i += 8;
            end else begin
                if (dat[i]) begin
                    lastp = -lastp;
                    set_sym(i, lastp);
                end else begin
                    set_sym(i, 0);
                end
                i++;
            end
        end
    endtask

    // invert polarity from one data mark on: exactly one lone violation
    task automatic inject(int n);
        for (int k = 60; k < n; k++) begin
            if (dat[k] && (sp[k] || sn[k]) && (sp[k-1] || sn[k-1])) begin
                for (int m = k; m < n; m++) begin
                    logic t = sp[m];
                    sp[m] = sn[m];
                    sn[m] = t;
                end
                ee[k] = 1'b1;
                break;
            end
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; lp = 1'b0; ln = 1'b0; en = 1'b1; fe = 1'b0; code = 2'd0;

        // table of directed vectors
        for (int t = 0; t < NV; t++) begin
            logic [66:0] v = VECS[t];
            code = v[66:65];
            en   = v[64];
            nsym = 16;
            for (int i = 0; i < 16; i++) begin
                sp[i] = v[63 - 2*i];
                sn[i] = v[62 - 2*i];
                ed[i] = v[31 - i];
                ee[i] = v[15 - i];
            end
            do_reset();
            run_stream(vec_req(t));
        end

        // random encoded streams with one injected violation each
        nsym = 200;
        code = 2'd0; en = 1'b1;
        gen_data(nsym); enc_ami(nsym); inject(nsym);
        do_reset(); run_stream("R2 R11");

        code = 2'd2;
        gen_data(nsym); enc_e1(nsym); inject(nsym);
        do_reset(); run_stream("R3 R4");

        code = 2'd1;
        gen_data(nsym); enc_t1(nsym); inject(nsym);
        do_reset(); run_stream("R6 R7");

        // R10: reset mid-stream clears outputs and last-mark memory
        code = 2'd0; en = 1'b1;
        do_reset();
        for (int j = 0; j < 12; j++) begin
            @(posedge clk); #1 lp = 1'b1; ln = 1'b0;
        end
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk); @(posedge clk); #7;
        check("R10", nrz, 1'b0, "data during reset");
        check("R10", flag, 1'b0, "flag during reset");
        @(posedge clk); #1 rst = 1'b0; lp = 1'b0;
        nsym = 4;
        set_sym(0, 1); set_sym(1, 0); set_sym(2, -1); set_sym(3, 0);
        ed[0] = 1; ed[1] = 0; ed[2] = 1; ed[3] = 0;
        for (int i = 0; i < 4; i++) ee[i] = 1'b0;
        run_stream("R10");

        // R9: output edge selection, one mark followed by zeros
        for (int m = 0; m < 2; m++) begin
            fe = (m == 1);
            do_reset();
            for (int j = 0; j < 11; j++) begin
                @(posedge clk);
                #1 lp = (j == 0); ln = 1'b0;
                #7;
                if (j == 8) check("R9", nrz, fe ? 1'b1 : 1'b0, $sformatf("edge mode %0d, cycle 8", m));
                if (j == 9) check("R9", nrz, fe ? 1'b0 : 1'b1, $sformatf("edge mode %0d, cycle 9", m));
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule